// File: doc/BRIEF.md
# Dual-Thread Vector Lane Arbiter

This block lets two independent instruction threads share a single vector execution resource. It is built from two ALU halves, each N/2 lanes wide, and one private bank of eight vector registers for each thread. Every cycle the arbiter looks at which threads want vector work and hands out the halves to match.

- **Both threads request:** each thread works through its operation on its own half, one lane chunk per cycle.
- **One thread requests:** its operation is spread over both halves and completes in a single cycle.

Each thread raises a request flag and supplies an opcode, two source register indices, a destination index and a lane immediate. It holds the request until its done strobe appears. A thread may lower its request in the middle of an operation to stall. It then resumes by presenting the same operation again.

On the cycle an operation finishes, the block returns a one-cycle done strobe for that thread. At the same time it shows the destination index and the full new destination value, and the register bank is updated at the closing clock edge. Scalar execution, fetch, decode and memory access are handled elsewhere.

Top module: `vec_dual_arb`

## Requirements
- R1: When both threads request in the same cycle, neither is done in that cycle. Each is done in the following cycle if both still request, having processed the lower lanes (0..N/2-1) first and the upper lanes second.
- R2: A thread requesting alone, with no half-finished operation, is done in the same cycle it requests, with all N lanes computed.
- R3: A thread whose lower lanes were written under contention, and which then requests alone (after any number of stalled cycles), is done in one cycle. Only the upper lanes are computed from current sources; the lower lanes already written are not recomputed, even when the destination is also a source.
- R4: Opcode 2'b00 gives lane-wise a+b and 2'b01 gives a-b, both modulo 2^W. Opcode 2'b10 gives the low W bits of a*b. Opcode 2'b11 loads lane i with imm+i modulo 2^W. a and b are the registers named by the two 3-bit source indices.
- R5: Each thread reads and writes only its own eight registers. An equal destination index in both threads does not make one thread's result visible to the other.
- R6: The done strobe is high for exactly one cycle per operation and only while that thread requests. In that cycle the write-back index equals the destination index, and the write-back data equals the new full destination value that takes effect at the next clock edge.
- R7: A synchronous active-high reset clears every register of both threads and drops any half-finished operation, so the next lone request computes all lanes.
- R8: With no request, no done strobe is raised and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Per-thread vector request (bit t = thread t) |
| op | input | 2x2 | Per-thread opcode |
| src_a | input | 2x3 | Per-thread first source register index |
| src_b | input | 2x3 | Per-thread second source register index |
| dst | input | 2x3 | Per-thread destination register index |
| imm | input | 2x16 | Per-thread lane immediate for the ramp load |
| done | output | 2 | Per-thread completion strobe |
| wb_idx | output | 2x3 | Per-thread write-back register index |
| wb_data | output | 2x256 | Per-thread full write-back value |

## Verification
The embedded assertions check three rules on every cycle:
- a done strobe only appears while its thread requests;
- a lone request always finishes in the cycle it is presented;
- two threads under contention never both complete in back-to-back contended cycles.

They also confirm that the register banks read as zero right after reset.

The remaining behaviour is only visible in the directed scenarios:
- the actual lane values of every opcode;
- whether register contents stay separate between threads;
- whether lower lanes are left untouched when a stalled operation resumes;
- whether a reset in the middle of an operation clears the stale half-state.

// File: rtl/vdat_pkg.sv
package vdat_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_MUL  = 2'b10,
      OP_RAMP = 2'b11
   } vop_e;
endpackage

// File: rtl/vdat_alu_half.sv
module vdat_alu_half
   import vdat_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int HALF   = 8,
   localparam int HW    = HALF * LANE_W
) (
   input  logic [1:0]        op,
   input  logic              chunk,
   input  logic [HW-1:0]     a,
   input  logic [HW-1:0]     b,
   input  logic [LANE_W-1:0] imm,
   output logic [HW-1:0]     y
);
   logic [LANE_W-1:0] base;
   assign base = chunk ? LANE_W'(HALF) : '0;

   for (genvar i = 0; i < HALF; i++) begin : g_lane
      logic [LANE_W-1:0] la, lb, lr;
      assign la = a[i*LANE_W +: LANE_W];
      assign lb = b[i*LANE_W +: LANE_W];
      always_comb begin
         unique case (op)
            OP_ADD:  lr = la + lb;
            OP_SUB:  lr = la - lb;
            OP_MUL:  lr = la * lb;
            default: lr = imm + base + LANE_W'(i);
         endcase
      end
      assign y[i*LANE_W +: LANE_W] = lr;
   end
endmodule

// File: rtl/vdat_regfile.sv
module vdat_regfile #(
   parameter int LANE_W = 16,
   parameter int LANES  = 16,
   parameter int NREG   = 8,
   localparam int IW    = $clog2(NREG),
   localparam int VW    = LANES * LANE_W,
   localparam int HW    = VW / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] ra,
   input  logic [IW-1:0] rb,
   input  logic [IW-1:0] rd,
   output logic [VW-1:0] rd_a,
   output logic [VW-1:0] rd_b,
   output logic [VW-1:0] rd_d,
   input  logic          we_lo,
   input  logic          we_hi,
   input  logic [HW-1:0] w_lo,
   input  logic [HW-1:0] w_hi
);
   logic [VW-1:0] mem [NREG];

   assign rd_a = mem[ra];
   assign rd_b = mem[rb];
   assign rd_d = mem[rd];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else begin
         if (we_lo) mem[rd][HW-1:0]  <= w_lo;
         if (we_hi) mem[rd][VW-1:HW] <= w_hi;
      end
   end

   // R7: every register reads as zero right after reset
   assert_clear_on_reset_R7: assert property (@(posedge clk)
      rst |=> (rd_a == '0 && rd_b == '0 && rd_d == '0));
endmodule

// File: rtl/vdat_sched.sv
module vdat_sched (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] req,
   output logic [1:0] act,
   output logic [1:0] own,
   output logic [1:0] chunk,
   output logic [1:0] wr_lo,
   output logic [1:0] wr_hi,
   output logic [1:0] done
);
   logic [1:0] pend, pend_n;
   logic       solo;

   assign solo = req[1];

   always_comb begin
      act    = '0;
      own    = '0;
      chunk  = '0;
      done   = '0;
      pend_n = pend;
      if (req == 2'b11) begin
         act    = 2'b11;
         own    = 2'b10;
         chunk  = pend;
         done   = pend;
         pend_n = ~pend;
      end else if (req != 2'b00) begin
         done[solo]   = 1'b1;
         pend_n[solo] = 1'b0;
         if (pend[solo]) begin
            act   = 2'b01;
            own   = {1'b0, solo};
            chunk = 2'b01;
         end else begin
            act   = 2'b11;
            own   = {solo, solo};
            chunk = 2'b10;
         end
      end
   end

   always_comb begin
      wr_lo = '0;
      wr_hi = '0;
      for (int k = 0; k < 2; k++) begin
         if (act[k]) begin
            if (chunk[k]) wr_hi[own[k]] = 1'b1;
            else          wr_lo[own[k]] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pend <= '0;
      else     pend <= pend_n;
   end
endmodule

// File: rtl/vec_dual_arb.sv
module vec_dual_arb #(
   parameter int LANES  = 16,
   parameter int LANE_W = 16,
   parameter int NREG   = 8,
   localparam int IW    = $clog2(NREG),
   localparam int VW    = LANES * LANE_W,
   localparam int HW    = VW / 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [1:0]            req,
   input  logic [1:0][1:0]       op,
   input  logic [1:0][IW-1:0]    src_a,
   input  logic [1:0][IW-1:0]    src_b,
   input  logic [1:0][IW-1:0]    dst,
   input  logic [1:0][LANE_W-1:0] imm,
   output logic [1:0]            done,
   output logic [1:0][IW-1:0]    wb_idx,
   output logic [1:0][VW-1:0]    wb_data
);
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("LANES must be even and at least 2");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end

   logic [1:0] act, own, chunk, wr_lo, wr_hi;
   logic [1:0][VW-1:0] da, db, dd;
   logic [1:0][HW-1:0] wlo, whi, ha, hb, hy;

   vdat_sched u_sched (
      .clk(clk), .rst(rst), .req(req), .act(act), .own(own),
      .chunk(chunk), .wr_lo(wr_lo), .wr_hi(wr_hi), .done(done)
   );

   for (genvar t = 0; t < 2; t++) begin : g_thr
      vdat_regfile #(.LANE_W(LANE_W), .LANES(LANES), .NREG(NREG)) u_rf (
         .clk(clk), .rst(rst), .ra(src_a[t]), .rb(src_b[t]), .rd(dst[t]),
         .rd_a(da[t]), .rd_b(db[t]), .rd_d(dd[t]),
         .we_lo(wr_lo[t]), .we_hi(wr_hi[t]), .w_lo(wlo[t]), .w_hi(whi[t])
      );

      assign wb_idx[t]  = dst[t];
      assign wb_data[t] = {wr_hi[t] ? whi[t] : dd[t][VW-1:HW],
                           wr_lo[t] ? wlo[t] : dd[t][HW-1:0]};

      // R6: completion only while the thread requests
      assert_done_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
         done[t] |-> req[t]);
      // R2/R3: a lone requester always finishes in the cycle it is served
      assert_solo_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
         (req == (2'b01 << t)) |-> done[t]);
      // R1: under contention an operation needs two halves
      assert_contend_two_cycles_R1: assert property (@(posedge clk) disable iff (rst)
         (req == 2'b11 && done[t]) |=> !(req == 2'b11 && done[t]));
   end

   for (genvar k = 0; k < 2; k++) begin : g_half
      always_comb begin
         ha[k] = chunk[k] ? da[own[k]][VW-1:HW] : da[own[k]][HW-1:0];
         hb[k] = chunk[k] ? db[own[k]][VW-1:HW] : db[own[k]][HW-1:0];
      end
      vdat_alu_half #(.LANE_W(LANE_W), .HALF(LANES/2)) u_alu (
         .op(op[own[k]]), .chunk(chunk[k]), .a(ha[k]), .b(hb[k]),
         .imm(imm[own[k]]), .y(hy[k])
      );
   end

   always_comb begin
      wlo = '0;
      whi = '0;
      for (int t = 0; t < 2; t++) begin
         for (int k = 0; k < 2; k++) begin
            if (act[k] && own[k] == 1'(t)) begin
               if (chunk[k]) whi[t] = hy[k];
               else          wlo[t] = hy[k];
            end
         end
      end
   end
endmodule

// File: tb/tb_vec_dual_arb.sv
`timescale 1ns/1ps
module tb_vec_dual_arb;
   localparam int LANES = 16, W = 16, NREG = 8, IW = 3, VW = LANES*W;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst;
   logic [1:0] req;
   logic [1:0][1:0] op;
   logic [1:0][IW-1:0] src_a, src_b, dst;
   logic [1:0][W-1:0] imm;
   logic [1:0] done;
   logic [1:0][IW-1:0] wb_idx;
   logic [1:0][VW-1:0] wb_data;

   vec_dual_arb dut (.clk(clk), .rst(rst), .req(req), .op(op), .src_a(src_a),
      .src_b(src_b), .dst(dst), .imm(imm), .done(done), .wb_idx(wb_idx),
      .wb_data(wb_data));

   int checks = 0, fails = 0;
   bit finished = 0;
   logic [VW-1:0] mdl [2][NREG];

   function automatic logic [VW-1:0] calc(logic [1:0] o, logic [VW-1:0] a,
                                          logic [VW-1:0] b, logic [W-1:0] im);
      logic [VW-1:0] r;
      for (int i = 0; i < LANES; i++) begin
         logic [W-1:0] x, y, z;
         x = a[i*W +: W];
         y = b[i*W +: W];
         case (o)
            2'b00: z = x + y;
            2'b01: z = x - y;
            2'b10: z = x * y;
            default: z = im + W'(i);
         endcase
         r[i*W +: W] = z;
      end
      return r;
   endfunction

   task automatic clear_model();
      for (int t = 0; t < 2; t++)
         for (int r = 0; r < NREG; r++) mdl[t][r] = '0;
   endtask

   task automatic drive(int t, bit r, logic [1:0] o, int a, int b, int d, int im);
      req[t] = r; op[t] = o; src_a[t] = IW'(a); src_b[t] = IW'(b);
      dst[t] = IW'(d); imm[t] = W'(im);
   endtask

   task automatic chk_done(string tag, logic [1:0] exp);
      checks++;
      if (done !== exp) begin
         fails++;
         $display("FAIL %s done: actual %b expected %b", tag, done, exp);
      end
   endtask

   task automatic chk_wb(string tag, int t, int d, logic [VW-1:0] e);
      checks++;
      if (wb_idx[t] !== IW'(d) || wb_data[t] !== e) begin
         fails++;
         $display("FAIL %s thread%0d wb: actual idx %0d data %h expected idx %0d data %h",
                  tag, t, wb_idx[t], wb_data[t], d, e);
      end
   endtask

   // advance to next drive point
   task automatic nxt();
      @(negedge clk);
   endtask

   // one solo operation, checked in its single cycle, then strobe drop checked
   task automatic solo(string tag, int t, logic [1:0] o, int a, int b, int d, int im);
      logic [VW-1:0] e;
      e = calc(o, mdl[t][a], mdl[t][b], W'(im));
      drive(t, 1, o, a, b, d, im);
      #1;
      chk_done(tag, 2'b01 << t);
      chk_wb(tag, t, d, e);
      mdl[t][d] = e;
      nxt();
      drive(t, 0, 2'b00, 0, 0, 0, 0);
      #1;
      chk_done({tag, " strobe drop R6"}, 2'b00);
      nxt();
   endtask

   task automatic t_reset_state();
      rst = 1; req = '0; op = '0; src_a = '0; src_b = '0; dst = '0; imm = '0;
      clear_model();
      repeat (3) nxt();
      #1;
      chk_done("reset state R7", 2'b00);
      rst = 0;
      nxt();
   endtask

   task automatic t_solo_ops();
      solo("ramp R2 R4", 0, 2'b11, 0, 0, 1, 5);
      solo("ramp R2 R4", 0, 2'b11, 0, 0, 2, 16'hFFF8);
      solo("add R4", 0, 2'b00, 1, 2, 3, 0);
      solo("sub R4", 0, 2'b01, 1, 2, 4, 0);
      solo("mul R4", 0, 2'b10, 2, 2, 5, 0);
      solo("ramp R2", 1, 2'b11, 0, 0, 1, 7);
      solo("ramp R2", 1, 2'b11, 0, 0, 2, 300);
      solo("mul R4", 1, 2'b10, 1, 2, 3, 0);
   endtask

   task automatic t_contend();
      logic [VW-1:0] e0, e1;
      e0 = calc(2'b11, '0, '0, 16'd11);
      e1 = calc(2'b11, '0, '0, 16'd222);
      drive(0, 1, 2'b11, 0, 0, 6, 11);
      drive(1, 1, 2'b11, 0, 0, 6, 222);
      #1;
      chk_done("contend first half R1", 2'b00);
      nxt();
      #1;
      chk_done("contend second half R1", 2'b11);
      chk_wb("contend R1 R5", 0, 6, e0);
      chk_wb("contend R1 R5", 1, 6, e1);
      mdl[0][6] = e0; mdl[1][6] = e1;
      nxt();
      drive(0, 0, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0, 0, 0);
      nxt();
      solo("own bank R5", 0, 2'b00, 6, 0, 7, 0);
      solo("own bank R5", 1, 2'b00, 6, 0, 7, 0);
   endtask

   task automatic t_resume();
      logic [VW-1:0] e0, e1;
      e0 = calc(2'b00, mdl[0][1], mdl[0][2], 0);
      e1 = calc(2'b01, mdl[1][2], mdl[1][1], 0);
      drive(0, 1, 2'b00, 1, 2, 1, 0);
      drive(1, 1, 2'b01, 2, 1, 2, 0);
      #1;
      chk_done("resume setup R1", 2'b00);
      nxt();
      drive(1, 0, 2'b01, 2, 1, 2, 0);
      #1;
      chk_done("pending alone R3", 2'b01);
      chk_wb("pending alone R3", 0, 1, e0);
      mdl[0][1] = e0;
      nxt();
      drive(0, 0, 0, 0, 0, 0, 0);
      #1;
      chk_done("stalled idle R8", 2'b00);
      nxt();
      nxt();
      drive(1, 1, 2'b01, 2, 1, 2, 0);
      #1;
      chk_done("resume after stall R3", 2'b10);
      chk_wb("resume no recompute R3", 1, 2, e1);
      mdl[1][2] = e1;
      nxt();
      drive(1, 0, 0, 0, 0, 0, 0);
      nxt();
   endtask

   task automatic t_idle();
      for (int c = 0; c < 5; c++) begin
         #1;
         chk_done("idle R8", 2'b00);
         nxt();
      end
      solo("idle no write R8", 0, 2'b00, 3, 0, 4, 0);
      solo("idle no write R8", 1, 2'b00, 3, 0, 4, 0);
   endtask

   task automatic t_reset_mid();
      drive(0, 1, 2'b11, 0, 0, 5, 1);
      drive(1, 1, 2'b11, 0, 0, 5, 2);
      nxt();
      drive(0, 0, 0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0, 0, 0);
      rst = 1;
      nxt();
      rst = 0;
      clear_model();
      solo("ramp after reset R7", 0, 2'b11, 0, 0, 3, 9);
      solo("ramp after reset R7", 1, 2'b11, 0, 0, 3, 40);
      solo("cleared bank R7", 0, 2'b00, 1, 2, 5, 0);
   endtask

   initial begin
      t_reset_state();
      t_solo_ops();
      t_contend();
      t_resume();
      t_idle();
      t_reset_mid();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule